// File: doc/BRIEF.md
# Predicated Execute Stage with Condition Flags

This block is the arithmetic end of a small 32-bit integer pipeline. It takes one already-decoded data-processing operation per cycle: move, add, subtract or compare. Each operation carries a 4-bit condition code, a set-flags bit and two operands. The first operand `srcA` is the base value. The second operand `srcB` is the value that is moved, added or subtracted. Before anything takes effect, the condition code is tested against the block's own negative, zero, carry and overflow flags. If the test fails, the operation is dropped and acts as a no-op.

An operation that passes its test produces a registered result and a one-cycle register-write pulse on the clock edge after it is presented. When asked to, it also updates the flags register on that same edge. Compare is a special case. It always updates the flags and never writes a result. Because the flags are updated on the same edge as the result, the next operation in the following cycle is tested against the flags that were just written, with no stall.

Top module: `cond_exec_alu`

## Requirements
- R1: On the edge after `inValid` with a passing condition, opcode 00 (move) loads `result` with `srcB`, 01 (add) loads `srcA+srcB` mod 2^32 and 10 (subtract) loads `srcA-srcB` mod 2^32, and `regWrite` is high for exactly that cycle. Otherwise `result` holds and `regWrite` is low.
- R2: Move, add and subtract with `setFlags` low leave `flags` unchanged.
- R3: Opcode 11 (compare) updates all four flags from `srcA-srcB` whatever `setFlags` is. It never raises `regWrite` and leaves `result` unchanged.
- R4: When the condition fails, the operation changes neither `result` nor `flags`, and `regWrite` stays low. Code 1111 never passes.
- R5: The single-flag codes behave as follows: 0000 passes on Z set, 0001 on Z clear, 0010 on C set, 0011 on C clear, 0100 on N set, 0101 on N clear, 0110 on V set and 0111 on V clear. Code 1110 always passes.
- R6: The compound codes behave as follows: 1000 passes on C set and Z clear, and 1001 on C clear or Z set. 1010 passes when N equals V, and 1011 when N differs from V. 1100 passes on Z clear with N equal to V, and 1101 on Z set or N differing from V.
- R7: `flags` is {N,Z,C,V} in bits [3:0]. N is result bit 31 and Z is set when the 32-bit result is zero. For add, C is the carry out and V is signed overflow. For subtract and compare, C is set when `srcA >= srcB` unsigned, and V is signed overflow. Move with `setFlags` updates only N and Z.
- R8: While `rstN` is low, `result`, `flags` and `regWrite` are all zero.
- R9: An operation presented in the cycle right after a flag-updating operation is tested against the updated flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | An operation is presented this cycle |
| opSel | input | 2 | 00 move, 01 add, 10 subtract, 11 compare |
| condCode | input | 4 | Condition code tested against the flags |
| setFlags | input | 1 | Request a flag update for move, add and subtract |
| srcA | input | 32 | First operand (base value) |
| srcB | input | 32 | Second operand |
| result | output | 32 | Last written result |
| regWrite | output | 1 | One-cycle pulse when `result` is written |
| flags | output | 4 | {N,Z,C,V} flags register |

## Verification
The bench walks the full carry and overflow corners. These are the all-ones plus one wrap, the largest positive plus one, the most negative minus one, and equal-operand compares. A design that produces a borrow instead of an inverted borrow, or gets the overflow sign test wrong, then makes every later compound condition take the wrong path. Every condition code, including 1111, is tested right after a compare that sets up a known flag pattern. This exposes swapped encodings, a forwarding slip where the test sees stale flags, and a never-code that executes. It also checks that a move with `setFlags` keeps C and V, and that compare ignores a low set-flags bit. A long random stream is compared against the reference model on every clock to catch leaks of `regWrite` or flag writes from failed or invalid operations.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    OP_MOV = 2'b00,
    OP_ADD = 2'b01,
    OP_SUB = 2'b10,
    OP_CMP = 2'b11
  } aluOp_e;

  typedef enum logic [3:0] {
    CC_EQ = 4'h0, CC_NE = 4'h1, CC_CS = 4'h2, CC_CC = 4'h3,
    CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
    CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
    CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  // strobes from control to datapath
  typedef struct packed {
    logic condPass;
    logic doWrite;
    logic updNZ;
    logic updCV;
    logic useSub;
    logic passB;
  } strobe_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] opSel,
  input  logic [3:0] condCode,
  input  logic       setFlags,
  input  flags_t     curFlags,
  output strobe_t    strb
);

  logic   condOk;
  aluOp_e op;

  assign op = aluOp_e'(opSel);

  always_comb begin
    unique case (cond_e'(condCode))
      CC_EQ:   condOk = curFlags.z;
      CC_NE:   condOk = !curFlags.z;
      CC_CS:   condOk = curFlags.c;
      CC_CC:   condOk = !curFlags.c;
      CC_MI:   condOk = curFlags.n;
      CC_PL:   condOk = !curFlags.n;
      CC_VS:   condOk = curFlags.v;
      CC_VC:   condOk = !curFlags.v;
      CC_HI:   condOk = curFlags.c && !curFlags.z;
      CC_LS:   condOk = !curFlags.c || curFlags.z;
      CC_GE:   condOk = (curFlags.n == curFlags.v);
      CC_LT:   condOk = (curFlags.n != curFlags.v);
      CC_GT:   condOk = !curFlags.z && (curFlags.n == curFlags.v);
      CC_LE:   condOk = curFlags.z || (curFlags.n != curFlags.v);
      CC_AL:   condOk = 1'b1;
      default: condOk = 1'b0;
    endcase
  end

  always_comb begin
    strb.condPass = inValid && condOk;
    strb.doWrite  = strb.condPass && (op != OP_CMP);
    strb.updNZ    = strb.condPass && ((op == OP_CMP) || setFlags);
    strb.updCV    = strb.updNZ && (op != OP_MOV);
    strb.useSub   = (op == OP_SUB) || (op == OP_CMP);
    strb.passB    = (op == OP_MOV);
  end

  AST_NEVER_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && condCode == 4'hF) |-> (!strb.doWrite && !strb.updNZ)); // R4

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  output logic [WIDTH-1:0] result,
  output logic             regWrite,
  output flags_t           flags
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bOperand;
  logic [WIDTH:0]   sumWide;
  logic [WIDTH-1:0] aluOut;
  logic             carryOut;
  logic             ovf;
  flags_t           flagsNext;

  assign bOperand = strb.useSub ? ~srcB : srcB;
  assign sumWide  = {1'b0, srcA} + {1'b0, bOperand} + {{WIDTH{1'b0}}, strb.useSub};
  assign carryOut = sumWide[WIDTH];
  assign aluOut   = strb.passB ? srcB : sumWide[MSB:0];
  assign ovf      = (srcA[MSB] == bOperand[MSB]) && (aluOut[MSB] != srcA[MSB]);

  always_comb begin
    flagsNext = flags;
    if (strb.updNZ) begin
      flagsNext.n = aluOut[MSB];
      flagsNext.z = (aluOut == '0);
    end
    if (strb.updCV) begin
      flagsNext.c = carryOut;
      flagsNext.v = ovf;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result   <= '0;
      regWrite <= 1'b0;
      flags    <= '0;
    end else begin
      regWrite <= strb.doWrite;
      flags    <= flagsNext;
      if (strb.doWrite) result <= aluOut;
    end
  end

  AST_CV_NEEDS_NZ: assert property (@(posedge clk) disable iff (!rstN)
    strb.updCV |-> strb.updNZ); // R7

  AST_WRITE_NEEDS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    strb.doWrite |-> strb.condPass); // R4

  AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !regWrite |-> result == $past(result)); // R1

endmodule

// File: rtl/cond_exec_alu.sv
module cond_exec_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [1:0]       opSel,
  input  logic [3:0]       condCode,
  input  logic             setFlags,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  output logic [WIDTH-1:0] result,
  output logic             regWrite,
  output logic [3:0]       flags
);

  strobe_t strb;
  flags_t  flagsQ;

  alu_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opSel    (opSel),
    .condCode (condCode),
    .setFlags (setFlags),
    .curFlags (flagsQ),
    .strb     (strb)
  );

  alu_datapath #(.WIDTH(WIDTH)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .srcA     (srcA),
    .srcB     (srcB),
    .result   (result),
    .regWrite (regWrite),
    .flags    (flagsQ)
  );

  assign flags = flagsQ;

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 2'b11) |=> !regWrite); // R3

  AST_FAIL_IS_NOP: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !strb.condPass) |=> (!regWrite && $stable(flags))); // R4

  AST_NOSET_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel != 2'b11 && !setFlags) |=> $stable(flags)); // R2

  AST_MOV_KEEPS_CV: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 2'b00) |=> $stable(flags[1:0])); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!regWrite && $stable(flags) && $stable(result))); // R1

endmodule

// File: tb/tb_cond_exec_alu.sv
module tb_cond_exec_alu;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [1:0]  opSel;
  logic [3:0]  condCode;
  logic        setFlags;
  logic [31:0] srcA, srcB;
  logic [31:0] result;
  logic        regWrite;
  logic [3:0]  flags;

  int checks = 0;
  int failures = 0;

  // reference model state
  logic [31:0] mRes;
  logic        mWe;
  logic [3:0]  mFlags; // {N,Z,C,V}
  string       lastTag;

  always #10 clk = ~clk; // 50 MHz

  cond_exec_alu dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .condCode(condCode), .setFlags(setFlags), .srcA(srcA), .srcB(srcB),
    .result(result), .regWrite(regWrite), .flags(flags)
  );

  function automatic bit condHolds(input logic [3:0] cc, input logic [3:0] f);
    bit n = f[3], z = f[2], c = f[1], v = f[0];
    case (cc)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c && !z;
      4'd9:  return !c || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic compareNow(input string tag);
    checks++;
    if (result !== mRes || regWrite !== mWe || flags !== mFlags) begin
      failures++;
      $display("FAIL %s result=%h/%h regWrite=%b/%b flags=%b/%b (actual/expected)",
               tag, result, mRes, regWrite, mWe, flags, mFlags);
    end
  endtask

  task automatic modelStep(input bit v, input logic [1:0] op, input logic [3:0] cc,
                           input bit s, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, sr;
    longint unsigned ua, ub;
    logic [31:0] r;
    bit cOut, vOut;
    mWe = 1'b0;
    if (v && condHolds(cc, mFlags)) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      ua = longint'(a);
      ub = longint'(b);
      cOut = 1'b0; vOut = 1'b0;
      case (op)
        2'd0: r = b;
        2'd1: begin
          r = a + b;
          cOut = (ua + ub) > 64'hFFFF_FFFF;
          sr = sa + sb;
          vOut = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
        end
        default: begin
          r = a - b;
          cOut = (ua >= ub);
          sr = sa - sb;
          vOut = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
        end
      endcase
      if (op != 2'd3) begin
        mRes = r;
        mWe = 1'b1;
      end
      if (op == 2'd3 || s) begin
        mFlags[3] = r[31];
        mFlags[2] = (r == 32'd0);
        if (op != 2'd0) begin
          mFlags[1] = cOut;
          mFlags[0] = vOut;
        end
      end
    end
  endtask

  // check the previous step's outcome, then present a new one
  task automatic issue(input bit v, input logic [1:0] op, input logic [3:0] cc,
                       input bit s, input logic [31:0] a, input logic [31:0] b,
                       input string tag);
    @(negedge clk);
    compareNow(lastTag);
    inValid = v; opSel = op; condCode = cc; setFlags = s; srcA = a; srcB = b;
    modelStep(v, op, cc, s, a, b);
    lastTag = tag;
  endtask

  function automatic logic [31:0] pickVal();
    case ($urandom_range(0, 7))
      0: return 32'h0;
      1: return 32'h1;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'hFFFF_FFFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    inValid = 1'b0; opSel = 2'd0; condCode = 4'hE; setFlags = 1'b0;
    srcA = '0; srcB = '0;
    mRes = '0; mWe = 1'b0; mFlags = '0;
    lastTag = "R8";
    repeat (3) @(negedge clk);
    compareNow("R8 reset");
    rstN = 1'b1;

    // R1 basic operations, R2 no flag change without set-flags
    issue(1, 2'd0, 4'hE, 0, 32'h0, 32'h1234_5678, "R1 move");
    issue(1, 2'd1, 4'hE, 0, 32'h10, 32'h22, "R1 add");
    issue(1, 2'd2, 4'hE, 0, 32'h5, 32'h7, "R1 sub wrap");
    issue(0, 2'd1, 4'hE, 1, 32'h1, 32'h1, "R1 idle");
    issue(1, 2'd1, 4'hE, 0, 32'hFFFF_FFFF, 32'h1, "R2 add no S");
    // R7 flag corners
    issue(1, 2'd1, 4'hE, 1, 32'hFFFF_FFFF, 32'h1, "R7 add wrap Z C");
    issue(1, 2'd1, 4'hE, 1, 32'h7FFF_FFFF, 32'h1, "R7 add ovf N V");
    issue(1, 2'd2, 4'hE, 1, 32'h5, 32'h3, "R7 sub no borrow");
    issue(1, 2'd2, 4'hE, 1, 32'h3, 32'h5, "R7 sub borrow");
    issue(1, 2'd2, 4'hE, 1, 32'h8000_0000, 32'h1, "R7 sub ovf");
    issue(1, 2'd0, 4'hE, 1, 32'h0, 32'h0, "R7 move keeps CV");
    issue(1, 2'd0, 4'hE, 1, 32'h0, 32'h8000_0000, "R7 move N");
    // R3 compare ignores set-flags and writes nothing
    issue(1, 2'd3, 4'hE, 0, 32'h9, 32'h9, "R3 cmp equal");
    issue(1, 2'd3, 4'hE, 1, 32'h1, 32'h2, "R3 cmp less");
    // R4 failing condition and code 1111
    issue(1, 2'd1, 4'h0, 1, 32'h1, 32'h1, "R4 EQ fails");
    issue(1, 2'd0, 4'hF, 1, 32'h0, 32'h0, "R4 never code");
    issue(1, 2'd3, 4'hF, 0, 32'h0, 32'h0, "R4 never cmp");

    // R5 / R6 / R9: every code right after a flag-setting compare
    for (int fs = 0; fs < 5; fs++) begin
      for (int cc = 0; cc < 16; cc++) begin
        logic [31:0] a, b;
        case (fs)
          0: begin a = 32'h0;         b = 32'h0;         end
          1: begin a = 32'h1;         b = 32'h2;         end
          2: begin a = 32'h8000_0000; b = 32'h1;         end
          3: begin a = 32'h2;         b = 32'h1;         end
          default: begin a = 32'h7FFF_FFFF; b = 32'hFFFF_FFFF; end
        endcase
        issue(1, 2'd3, 4'hE, 0, a, b, "R9 setup cmp");
        issue(1, 2'd0, 4'(cc), 0, 32'h0, 32'hA000_0000 + 32'(cc),
              (cc < 8 || cc == 14) ? "R5 simple code" :
              (cc == 15) ? "R4 never" : "R6 compound code");
      end
    end

    // R9 long mixed stream
    for (int i = 0; i < 3000; i++) begin
      issue($urandom_range(0, 5) != 0, 2'($urandom_range(0, 3)),
            4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
            pickVal(), pickVal(), "R9 random");
    end

    @(negedge clk);
    compareNow(lastTag);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule